// File: doc/BRIEF.md
# Configurable Logic Slice

This block models one programmable logic slice. Two 4-input look-up tables each index a 16-entry truth table. A wide-function mux joins the two tables so the slice can realize a 5-input function. The first table also drives a carry mux and a dedicated sum XOR, which lets a chain of slices build a ripple adder one bit per slice. A partial-product AND can feed the carry mux, so one table per bit performs both the multiply and the add of a multiply-accumulate step. Two storage elements each take either the combinational path or a bypass input. Each one can be set to act as an edge-triggered flip-flop or as a level-sensitive latch.

Configuration is loaded serially through `cfg_din` while `cfg_en` is high, one bit per rising edge of `clk`. Every output reads zero during loading. Clock, clock enable, set and reset are shared by both storage elements. Each of these controls has its own configuration bit that inverts it. A further bit chooses whether set and reset act synchronously or asynchronously.

Top module: `cfg_logic_slice`

## Requirements
- R1: While `cfg_en` is high, each rising `clk` edge shifts `cfg_din` into a 44-bit configuration word, most significant bit first. Bits [15:0] hold table G and bits [31:16] hold table H. Control bit c maps to word bit 32+c: c0 = X shows the sum, c1 = Y shows the wide mux, c2 = carry operand is the AND product, c3 = X storage bypass, c4 = Y storage bypass, c5 = X latch mode, c6 = Y latch mode, c7 = asynchronous set/reset, c8 = invert clock, c9 = invert clock enable, c10 = invert set, c11 = invert reset.
- R2: While `cfg_en` is high, `x_o`, `y_o`, `cout`, `xq` and `yq` are all 0, and both storage elements are cleared.
- R3: The output of each table is the table bit whose index equals the numeric value of its 4 inputs. With c0 = 0, `x_o` equals the output of G. With c1 = 0, `y_o` equals the output of H.
- R4: With c1 = 1, `y_o` equals the output of H when `f5_sel` = 1 and the output of G when `f5_sel` = 0.
- R5: With c0 = 1, `x_o` is the output of G XOR `cin`. With c0 = 0, `cin` has no effect on `x_o`.
- R6: `cout` equals `cin` when G outputs 1. Otherwise `cout` equals the carry operand. The carry operand is `g_in[0]` when c2 = 0 and `g_in[0] & g_in[1]` when c2 = 1.
- R7: Each storage element takes its bypass input (`bx`, `by`) when its bypass bit is 1. Otherwise it takes the slice's combinational output (`x_o` or `y_o`).
- R8: In flip-flop mode the element captures on the active clock edge only while the effective clock enable is 1. Otherwise it holds its value.
- R9: In latch mode the element follows its input while both the effective clock and the effective clock enable are 1. Otherwise it holds its value.
- R10: With c7 = 0, set and reset take effect only on an active edge, whether or not clock enable is active. When both are asserted, reset wins.
- R11: With c7 = 1, set and reset take effect at once, with no clock edge. When both are asserted, reset wins.
- R12: Bits c8 to c11 invert clock, clock enable, set and reset. With c8 = 1 the flip-flops capture on the falling edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration shift clock and storage clock |
| cfg_en | input | 1 | Configuration load enable; also holds the outputs at zero |
| cfg_din | input | 1 | Serial configuration data |
| g_in | input | 4 | Inputs of table G |
| h_in | input | 4 | Inputs of table H |
| f5_sel | input | 1 | Select for the wide-function mux |
| cin | input | 1 | Carry from the slice below |
| bx | input | 1 | Bypass data for the X storage element |
| by | input | 1 | Bypass data for the Y storage element |
| ce | input | 1 | Shared clock enable |
| set_in | input | 1 | Shared set |
| rst_in | input | 1 | Shared reset |
| x_o | output | 1 | Combinational X output |
| y_o | output | 1 | Combinational Y output |
| cout | output | 1 | Carry to the slice above |
| xq | output | 1 | X storage output |
| yq | output | 1 | Y storage output |

## Verification
The bench builds the slice with the default 4-input tables, which gives a 44-bit word. At that size it can sweep every input index of both tables and every operand and carry combination of the adder and the partial-product adder. Each scenario reloads the whole word serially, so the shift order is checked again every time. The storage tests cover flip-flop and latch modes, both set/reset timings, and every control inversion, including capture on the falling edge.

// File: rtl/cfg_logic_slice.sv
module cfg_logic_slice #(
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         cfg_en,
  input  logic         cfg_din,
  input  logic [K-1:0] g_in,
  input  logic [K-1:0] h_in,
  input  logic         f5_sel,
  input  logic         cin,
  input  logic         bx,
  input  logic         by,
  input  logic         ce,
  input  logic         set_in,
  input  logic         rst_in,
  output logic         x_o,
  output logic         y_o,
  output logic         cout,
  output logic         xq,
  output logic         yq
);
  localparam int TBL = 1 << K;
  localparam int NCTL = 12;
  localparam int CW = 2 * TBL + NCTL;

  logic [CW-1:0] cfg;

  always_ff @(posedge clk)
    if (cfg_en) cfg <= {cfg[CW-2:0], cfg_din};

  logic [TBL-1:0]  tab_g, tab_h;
  logic [NCTL-1:0] ctl;
  assign tab_g = cfg[TBL-1:0];
  assign tab_h = cfg[2*TBL-1:TBL];
  assign ctl   = cfg[CW-1:2*TBL];

  logic x_sum, y_wide, mult, sr_async, inv_ck, inv_ce, inv_st, inv_rs;
  logic [1:0] byp, latch_m;
  assign x_sum    = ctl[0];
  assign y_wide   = ctl[1];
  assign mult     = ctl[2];
  assign byp      = ctl[4:3];
  assign latch_m  = ctl[6:5];
  assign sr_async = ctl[7];
  assign inv_ck   = ctl[8];
  assign inv_ce   = ctl[9];
  assign inv_st   = ctl[10];
  assign inv_rs   = ctl[11];

  logic gv, hv, wide, dsel, carry, xc, yc;
  assign gv    = tab_g[g_in];
  assign hv    = tab_h[h_in];
  assign wide  = f5_sel ? hv : gv;
  assign dsel  = mult ? (g_in[0] & g_in[1]) : g_in[0];
  assign carry = gv ? cin : dsel;
  assign xc    = x_sum ? (gv ^ cin) : gv;
  assign yc    = y_wide ? wide : hv;

  logic ck_e, ce_e, st_e, rs_e, a_clr, a_set, s_clr, s_set;
  assign ck_e  = clk ^ inv_ck;
  assign ce_e  = ce ^ inv_ce;
  assign st_e  = set_in ^ inv_st;
  assign rs_e  = rst_in ^ inv_rs;
  assign a_clr = cfg_en | (sr_async & rs_e);
  assign a_set = ~cfg_en & sr_async & st_e & ~rs_e;
  assign s_clr = ~sr_async & rs_e;
  assign s_set = ~sr_async & st_e;

  logic [1:0] d, q;
  assign d[0] = byp[0] ? bx : xc;
  assign d[1] = byp[1] ? by : yc;

  for (genvar i = 0; i < 2; i++) begin : g_store
    logic ff_q, lt_q;

    always_ff @(posedge ck_e or posedge a_clr or posedge a_set)
      if (a_clr)      ff_q <= 1'b0;
      else if (a_set) ff_q <= 1'b1;
      else if (s_clr) ff_q <= 1'b0;
      else if (s_set) ff_q <= 1'b1;
      else if (ce_e)  ff_q <= d[i];

    always_latch
      if (a_clr)              lt_q <= 1'b0;
      else if (a_set)         lt_q <= 1'b1;
      else if (ck_e && ce_e)  lt_q <= s_clr ? 1'b0 : (s_set ? 1'b1 : d[i]);

    assign q[i] = latch_m[i] ? lt_q : ff_q;

    assert_ce_hold_R8: assert property (@(posedge clk) disable iff (cfg_en)
      (!latch_m[i] && !sr_async && !inv_ck && !ce_e && !st_e && !rs_e) |=> $stable(q[i]));

    assert_sync_set_R10: assert property (@(posedge clk) disable iff (cfg_en)
      (!latch_m[i] && !sr_async && !inv_ck && st_e && !rs_e) |=> q[i]);

    assert_reset_wins_R10: assert property (@(posedge clk) disable iff (cfg_en)
      (!latch_m[i] && !sr_async && !inv_ck && rs_e) |=> !q[i]);
  end

  assign x_o  = ~cfg_en & xc;
  assign y_o  = ~cfg_en & yc;
  assign cout = ~cfg_en & carry;
  assign xq   = ~cfg_en & q[0];
  assign yq   = ~cfg_en & q[1];

  assert_load_quiet_R2: assert property (@(posedge clk)
    cfg_en |-> ({x_o, y_o, cout, xq, yq} == 5'b0));

  assert_async_clear_R11: assert property (@(posedge clk) disable iff (cfg_en)
    (sr_async && rs_e) |-> (!xq && !yq));

  assert_sum_carry_R6: assert property (@(posedge clk) disable iff (cfg_en)
    (x_sum && cout != cin) |-> (x_o == cin));
endmodule

// File: tb/cfg_logic_slice_test.sv
module cfg_logic_slice_test;
  localparam int CW = 44;

  logic clk = 1'b0;
  logic cfg_en = 1'b1, cfg_din = 1'b0;
  logic [3:0] g_in = '0, h_in = '0;
  logic f5_sel = 0, cin = 0, bx = 0, by = 0, ce = 0, set_in = 0, rst_in = 0;
  logic x_o, y_o, cout, xq, yq;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  cfg_logic_slice uut (
    .clk(clk), .cfg_en(cfg_en), .cfg_din(cfg_din), .g_in(g_in), .h_in(h_in),
    .f5_sel(f5_sel), .cin(cin), .bx(bx), .by(by), .ce(ce), .set_in(set_in),
    .rst_in(rst_in), .x_o(x_o), .y_o(y_o), .cout(cout), .xq(xq), .yq(yq)
  );

  always #5 clk = ~clk;

  task automatic step;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [11:0] ctl, input logic [15:0] h, input logic [15:0] g);
    logic [CW-1:0] w;
    w = {ctl, h, g};
    cfg_en = 1'b1;
    for (int i = CW - 1; i >= 0; i--) begin
      cfg_din = w[i];
      step;
      if (i == 20) chk("R2 quiet while loading", {3'b0, x_o, y_o, cout, xq, yq}, 8'h0);
    end
    cfg_en = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    step; step;
    chk("R2 initial outputs", {3'b0, x_o, y_o, cout, xq, yq}, 8'h0);
  endtask

  task automatic t_lut;
    logic [15:0] tg, th;
    tg = 16'hE817; th = 16'h3C5A;
    cin = 1'b1;
    load(12'h000, th, tg);
    for (int i = 0; i < 16; i++) begin
      g_in = 4'(i); h_in = 4'(15 - i);
      #1;
      chk("R1 R3 R5 table G on x_o", {7'b0, x_o}, {7'b0, tg[i]});
      chk("R1 R3 table H on y_o", {7'b0, y_o}, {7'b0, th[15 - i]});
    end
    cin = 1'b0;
  endtask

  task automatic t_f5;
    load(12'h002, 16'hFF00, 16'h00F0);
    g_in = 4'd4; h_in = 4'd4; f5_sel = 0; #1;
    chk("R4 wide mux picks G", {7'b0, y_o}, 8'h1);
    f5_sel = 1; #1;
    chk("R4 wide mux picks H", {7'b0, y_o}, 8'h0);
    g_in = 4'd8; h_in = 4'd8; #1;
    chk("R4 wide mux picks H", {7'b0, y_o}, 8'h1);
    f5_sel = 0; #1;
    chk("R4 wide mux picks G", {7'b0, y_o}, 8'h0);
  endtask

  task automatic t_add;
    load(12'h001, 16'h0000, 16'h6666);
    for (int v = 0; v < 8; v++) begin
      logic a, b, c;
      a = v[0]; b = v[1]; c = v[2];
      g_in = {2'b00, b, a}; cin = c;
      #1;
      chk("R5 sum bit", {7'b0, x_o}, {7'b0, a ^ b ^ c});
      chk("R6 carry out", {7'b0, cout}, {7'b0, (a & b) | (c & (a ^ b))});
    end
    cin = 0;
  endtask

  task automatic t_mul;
    logic [15:0] tg;
    for (int i = 0; i < 16; i++) tg[i] = (i[0] & i[1]) ^ i[2];
    load(12'h005, 16'h0000, tg);
    for (int v = 0; v < 16; v++) begin
      logic pp, s, c;
      pp = v[0] & v[1]; s = v[2]; c = v[3];
      g_in = {1'b0, v[2], v[1], v[0]}; cin = c;
      #1;
      chk("R6 product-add sum", {7'b0, x_o}, {7'b0, pp ^ s ^ c});
      chk("R6 product-add carry", {7'b0, cout}, {7'b0, (pp & s) | (c & (pp ^ s))});
    end
    cin = 0; g_in = '0;
  endtask

  task automatic t_ff_sync;
    load(12'h008, 16'hFFFF, 16'h0000);
    ce = 1; bx = 1; step;
    chk("R7 R8 X bypass captured", {7'b0, xq}, 8'h1);
    chk("R7 Y from table H", {7'b0, yq}, 8'h1);
    ce = 0; bx = 0; step;
    chk("R8 hold with enable low", {7'b0, xq}, 8'h1);
    rst_in = 1; set_in = 1; step;
    chk("R10 reset wins", {6'b0, xq, yq}, 8'h0);
    rst_in = 0; step;
    chk("R10 sync set without enable", {6'b0, xq, yq}, 8'h3);
    set_in = 0; rst_in = 1; #1;
    chk("R10 reset waits for edge", {7'b0, xq}, 8'h1);
    step;
    chk("R10 sync reset on edge", {7'b0, xq}, 8'h0);
    rst_in = 0;
  endtask

  task automatic t_async;
    load(12'h088, 16'h0000, 16'h0000);
    ce = 1; bx = 1; step;
    chk("R8 capture before async test", {7'b0, xq}, 8'h1);
    rst_in = 1; #1;
    chk("R11 async reset immediate", {7'b0, xq}, 8'h0);
    rst_in = 0; set_in = 1; #1;
    chk("R11 async set immediate", {7'b0, xq}, 8'h1);
    rst_in = 1; #1;
    chk("R11 reset wins", {6'b0, xq, yq}, 8'h0);
    rst_in = 0; set_in = 0; bx = 0;
  endtask

  task automatic t_latch;
    load(12'h028, 16'h0000, 16'h0000);
    ce = 1; step;
    bx = 1; #1;
    chk("R9 latch transparent", {7'b0, xq}, 8'h1);
    bx = 0; #1;
    chk("R9 latch follows", {7'b0, xq}, 8'h0);
    bx = 1; #1;
    @(negedge clk); #1;
    bx = 0; #1;
    chk("R9 latch holds with clock low", {7'b0, xq}, 8'h1);
    step;
    ce = 0; #1;
    bx = 1; #1; bx = 0; #1;
    chk("R9 latch holds with enable low", {7'b0, xq}, 8'h0);
  endtask

  task automatic t_inv;
    rst_in = 1; ce = 0; set_in = 0;
    load(12'hB08, 16'h0000, 16'h0000);
    bx = 1; #1;
    chk("R12 no capture on rising edge", {7'b0, xq}, 8'h0);
    @(negedge clk); #1;
    chk("R12 capture on falling edge, enable inverted", {7'b0, xq}, 8'h1);
    ce = 1; bx = 0;
    @(negedge clk); #1;
    chk("R12 inverted enable blocks", {7'b0, xq}, 8'h1);
    rst_in = 0;
    @(negedge clk); #1;
    chk("R12 inverted reset", {7'b0, xq}, 8'h0);
    set_in = 1; rst_in = 0;
    load(12'h488, 16'h0000, 16'h0000);
    chk("R12 inverted set idle", {7'b0, xq}, 8'h0);
    set_in = 0; #1;
    chk("R12 inverted async set", {6'b0, xq, yq}, 8'h3);
    set_in = 1; ce = 0;
  endtask

  initial begin
    t_reset;
    t_lut;
    t_f5;
    t_add;
    t_mul;
    t_ff_sync;
    t_async;
    t_latch;
    t_inv;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule